// File: doc/BRIEF.md
# Programmable Long-Delay Timer

This block is a digital long-delay timer. A time base divides the system clock down to one tick every T clock cycles, where T is a 16-bit programmable cycle count. An 8-bit binary counter counts those ticks. A rising edge on the start input restarts the time base and clears the counter. A rising edge on the stop input halts the time base.

The delay is chosen with a tap mask rather than a compare value. Every counter bit that is selected by the mask is merged onto one active-low output. That output stays low while any selected bit is still zero. The delay therefore equals the sum of the weights of the selected bits, times T. For example, a mask of 0x20 gives 32T, and a mask of 0x89 gives 137T.

In one-shot mode the timer stops when its delay has elapsed. In free-running mode it wraps back to zero by itself. That turns the output into a pulse train whose period is set by the mask, giving 256 possible output rates from a single base period.

Top module: `long_delay_timer`

## Requirements
- R1: While `rst` is high, and after its release until the first start edge, `count_q` reads 0xFF, `delay_n` reads 1 and the timer is idle.
- R2: When `start_in` is sampled high after being sampled low at the previous edge, and the timer is idle, `count_q` reads 0 from the next clock. The time base restarts from the beginning of a period.
- R3: While running, the counter advances by one every P clock cycles, where P is `base_period` and a `base_period` of 0 counts as 1. The first advance is P cycles after the accepting edge.
- R4: `delay_n` is 1 exactly when every bit that is set in `tap_mask`, as sampled at the edge that loaded `count_q`, is also 1 in `count_q`.
- R5: With `free_run` = 0 (one-shot) and a nonzero mask M, `delay_n` is low for exactly M×P cycles after a start. Then the counter holds the value M and the timer stops. This gives 32P for a mask of 0x20 and 137P for a mask of 0x89.
- R6: With `free_run` = 1, when a tick arrives while every selected bit is 1, the counter returns to 0 and keeps running. `delay_n` then repeats with a period of (M+1)×P cycles and is high for P cycles of each period.
- R7: A rising edge on `stop_in` stops the timer at the next clock. `count_q` then holds its value until the next accepted start.
- R8: A start edge that arrives while the timer is running is ignored. The counter continues its sequence without clearing.
- R9: When rising edges on `stop_in` and `start_in` are seen at the same clock, the stop wins. An idle timer stays idle and keeps its count.
- R10: In one-shot mode with a mask of 0, `delay_n` stays 1. The counter advances from 0 to 1 on the first tick and then stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Start request; acts on its rising edge |
| stop_in | input | 1 | Stop request; acts on its rising edge |
| free_run | input | 1 | 0 = one-shot, 1 = free-running restart |
| tap_mask | input | 8 | Selects which counter bits are merged onto `delay_n` |
| base_period | input | 16 | Time-base period in clock cycles (0 treated as 1) |
| count_q | output | 8 | Counter bits |
| delay_n | output | 1 | Merged active-low delay output |

## Verification
Some events can fall in the same clock. A stop edge and a start edge can arrive together, and a start edge can coincide with a running tick. The first case is provoked on an idle timer by raising both inputs in one cycle; the expected result is that the count stays frozen and never clears. The second case is provoked by re-raising the start input in the middle of a one-shot delay; the expected result is that the measured low time is still exactly M×P. A behavioural model in the bench follows every clock and also judges the cycle where the one-shot end or the free-run wrap meets the last tick.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  parameter int CNT_W = 8;
  parameter int PER_W = 16;

  typedef enum logic {
    MODE_ONE_SHOT = 1'b0,
    MODE_FREE_RUN = 1'b1
  } run_mode_e;
endpackage

// File: rtl/ltc_rise.sv
module ltc_rise (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/ltc_timebase.sv
module ltc_timebase #(
  parameter int PER_W = ltc_pkg::PER_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] div_q;
  logic [PER_W-1:0] period_eff;
  logic [PER_W-1:0] last_phase;

  assign period_eff = (period == '0) ? PER_W'(1) : period;
  assign last_phase = PER_W'(period_eff - 1'b1);
  assign tick       = run && (div_q >= last_phase);

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= PER_W'(div_q + 1'b1);
  end

  // R3: with a period above one, two ticks are never adjacent
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && period_eff > PER_W'(1)) |=> (!tick || !$stable(period_eff)));
endmodule

// File: rtl/ltc_tap_counter.sv
module ltc_tap_counter #(
  parameter int CNT_W = ltc_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_edge,
  input  logic             stop_edge,
  input  logic             tick,
  input  logic             free_run,
  input  logic [CNT_W-1:0] tap_mask,
  output logic             running,
  output logic [CNT_W-1:0] count_q,
  output logic             delay_n
);
  import ltc_pkg::*;

  run_mode_e        mode;
  logic             accept;
  logic             run_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cnt_inc;

  function automatic logic taps_high(input logic [CNT_W-1:0] v,
                                     input logic [CNT_W-1:0] m);
    return &(v | ~m);
  endfunction

  assign mode    = run_mode_e'(free_run);
  assign accept  = start_edge && !running && !stop_edge;
  assign cnt_inc = CNT_W'(count_q + 1'b1);

  always_comb begin
    run_nxt = running;
    cnt_nxt = count_q;
    if (stop_edge) begin
      run_nxt = 1'b0;
    end else if (accept) begin
      run_nxt = 1'b1;
      cnt_nxt = '0;
    end else if (running && tick) begin
      if (mode == MODE_FREE_RUN) begin
        cnt_nxt = taps_high(count_q, tap_mask) ? '0 : cnt_inc;
      end else begin
        cnt_nxt = cnt_inc;
        if (taps_high(cnt_inc, tap_mask)) run_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      count_q <= '1;
      delay_n <= 1'b1;
    end else begin
      running <= run_nxt;
      count_q <= cnt_nxt;
      delay_n <= taps_high(cnt_nxt, tap_mask);
    end
  end

  // R2: a timer that just started begins from zero
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> (count_q == '0));

  // R7: a stop edge leaves the timer idle
  assert_stop_halts_R7: assert property (@(posedge clk) disable iff (rst)
    stop_edge |=> !running);

  // R8: a start during a run does not end the run
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (start_edge && running && !stop_edge && !tick) |=> (running && $stable(count_q)));

  // R3: without a tick or an accepted start the count does not move
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !accept) |=> $stable(count_q));

  // R5: a one-shot that ends by itself has every selected bit high
  assert_oneshot_end_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(running) && !$past(stop_edge) && !$past(free_run))
      |-> ((count_q & $past(tap_mask)) == $past(tap_mask)));
endmodule

// File: rtl/long_delay_timer.sv
module long_delay_timer #(
  parameter int CNT_W = ltc_pkg::CNT_W,
  parameter int PER_W = ltc_pkg::PER_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_in,
  input  logic             stop_in,
  input  logic             free_run,
  input  logic [CNT_W-1:0] tap_mask,
  input  logic [PER_W-1:0] base_period,
  output logic [CNT_W-1:0] count_q,
  output logic             delay_n
);
  localparam int N_EDGE = 2;

  logic [N_EDGE-1:0] raw_in;
  logic [N_EDGE-1:0] rise_v;
  logic              running;
  logic              tick;

  assign raw_in = {stop_in, start_in};

  for (genvar g = 0; g < N_EDGE; g++) begin : g_rise
    ltc_rise u_rise (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .rise (rise_v[g])
    );
  end

  ltc_timebase #(.PER_W(PER_W)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .run    (running),
    .period (base_period),
    .tick   (tick)
  );

  ltc_tap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .start_edge (rise_v[0]),
    .stop_edge  (rise_v[1]),
    .tick       (tick),
    .free_run   (free_run),
    .tap_mask   (tap_mask),
    .running    (running),
    .count_q    (count_q),
    .delay_n    (delay_n)
  );

  // R9: coincident stop and start never leave the timer running
  assert_stop_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (rise_v[0] && rise_v[1]) |=> !running);
endmodule

// File: tb/sim_long_delay_timer.sv
module sim_long_delay_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_in = 1'b0;
  logic        stop_in = 1'b0;
  logic        free_run = 1'b0;
  logic [7:0]  tap_mask = 8'h00;
  logic [15:0] base_period = 16'd1;
  logic [7:0]  count_q;
  logic        delay_n;

  int compared = 0;
  int mismatched = 0;
  bit started = 0;

  // behavioural reference state
  int m_run = 0, m_cnt = 255, m_div = 0, m_ps = 0, m_pp = 0, m_out = 1;

  always #2 clk = ~clk;

  long_delay_timer u0 (
    .clk(clk), .rst(rst), .start_in(start_in), .stop_in(stop_in),
    .free_run(free_run), .tap_mask(tap_mask), .base_period(base_period),
    .count_q(count_q), .delay_n(delay_n)
  );

  function automatic int covered(int c, int m);
    return ((c & m) == m) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_run = 0; m_cnt = 255; m_div = 0; m_ps = 0; m_pp = 0; m_out = 1;
    end else begin
      int se, pe, p, tk, nrun, ncnt, ndiv;
      se = (start_in && !m_ps) ? 1 : 0;
      pe = (stop_in && !m_pp) ? 1 : 0;
      m_ps = start_in; m_pp = stop_in;
      p = (base_period == 0) ? 1 : int'(base_period);
      tk = (m_run && m_div >= p - 1) ? 1 : 0;
      ndiv = (!m_run || tk) ? 0 : m_div + 1;
      nrun = m_run; ncnt = m_cnt;
      if (pe) nrun = 0;
      else if (se && !m_run) begin nrun = 1; ncnt = 0; end
      else if (m_run && tk) begin
        if (free_run) ncnt = covered(m_cnt, tap_mask) ? 0 : (m_cnt + 1) % 256;
        else begin
          ncnt = (m_cnt + 1) % 256;
          if (covered(ncnt, tap_mask)) nrun = 0;
        end
      end
      m_run = nrun; m_cnt = ncnt; m_div = ndiv;
      m_out = covered(m_cnt, tap_mask);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R3 count model", int'(count_q), m_cnt);
      chk("R4 output model", int'(delay_n), m_out);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic pulse_start();
    start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (delay_n == 1'b0 && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, hold;
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count_q), 255);
    chk("R1 reset output", int'(delay_n), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle count", int'(count_q), 255);

    // R5: weight 32 with P=2
    tap_mask = 8'h20; base_period = 16'd2; free_run = 1'b0;
    @(negedge clk);
    pulse_start();
    chk("R2 cleared", int'(count_q), 0);
    measure_low(n);
    chk("R5 delay 32T", n, 64);
    chk("R5 final count", int'(count_q), 32);
    repeat (5) @(negedge clk);
    chk("R5 stopped", int'(count_q), 32);

    // R5: weights 1+8+128 with P=1
    tap_mask = 8'h89; base_period = 16'd1;
    @(negedge clk);
    pulse_start();
    measure_low(n);
    chk("R5 delay 137T", n, 137);

    // R3: period 0 acts as 1
    tap_mask = 8'h05; base_period = 16'd0;
    @(negedge clk);
    pulse_start();
    measure_low(n);
    chk("R3 period zero", n, 5);

    // R3: period 3, full mask
    tap_mask = 8'hFF; base_period = 16'd3;
    @(negedge clk);
    pulse_start();
    measure_low(n);
    chk("R3 R4 full range", n, 765);

    // R8: restart during a run is ignored
    tap_mask = 8'h14; base_period = 16'd1;
    @(negedge clk);
    pulse_start();
    n = 0;
    while (delay_n == 1'b0 && n < 1000) begin
      n++;
      if (n == 5) start_in = 1'b1;
      if (n == 6) start_in = 1'b0;
      @(negedge clk);
    end
    chk("R8 ignored start", n, 20);

    // R6: free-running, M=3, P=2
    tap_mask = 8'h03; base_period = 16'd2; free_run = 1'b1;
    @(negedge clk);
    pulse_start();
    measure_low(n);
    chk("R6 first low", n, 6);
    n = 0;
    while (delay_n == 1'b1 && n < 1000) begin n++; @(negedge clk); end
    chk("R6 high width", n, 2);
    measure_low(n);
    chk("R6 low width", n, 6);

    // R7: stop freezes the count
    repeat (3) @(negedge clk);
    stop_in = 1'b1;
    @(negedge clk);
    stop_in = 1'b0;
    hold = int'(count_q);
    repeat (20) @(negedge clk);
    chk("R7 count held", int'(count_q), hold);

    // R9: coincident start and stop on an idle timer
    start_in = 1'b1; stop_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0; stop_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 stop wins", int'(count_q), hold);

    // R10: empty mask in one-shot
    tap_mask = 8'h00; free_run = 1'b0; base_period = 16'd4;
    @(negedge clk);
    pulse_start();
    chk("R10 output high", int'(delay_n), 1);
    repeat (12) @(negedge clk);
    chk("R10 count one", int'(count_q), 1);
    chk("R10 output stays", int'(delay_n), 1);

    // R2: restart after a finished one-shot
    tap_mask = 8'h02; base_period = 16'd1;
    @(negedge clk);
    pulse_start();
    chk("R2 restart clear", int'(count_q), 0);
    measure_low(n);
    chk("R2 R5 short delay", n, 2);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule